// File: doc/BRIEF.md
# Direct Torque Control Vector Selector

This block chooses the inverter voltage vector in a direct-torque-controlled induction motor drive. Once per control period a strobe arrives with four signed magnitudes (commanded and estimated stator flux, commanded and estimated torque), two programmable band widths and the stator flux sector, numbered 1 to 6. A two-level hysteresis comparator turns the flux error into a raise/lower demand. A three-level hysteresis comparator turns the torque error into a raise, hold or lower demand. The two demands and the sector index a fixed six-sector switching table. The resulting leg states are registered into an output buffer with a one-cycle valid pulse. Inverter control logic reads that buffer.

Between strobes every output holds. The band widths and the magnitudes have an effect only in the cycle the strobe is high. When the torque demand is zero, the block picks whichever zero vector needs the fewer leg transitions from the vector it applied last.

Top module: `dtc_vector_select`

## Requirements
- R1: After reset, legState is 3'b000, legValid is 0, fluxUp is 0 and torqueDemand is 2'b00.
- R2: legValid is 1 in exactly the cycle after each clock edge that samples cycleStrobe high. Without a strobe, legState, fluxUp and torqueDemand keep their values.
- R3: The flux error is fluxRef minus fluxEst, computed without overflow. On a strobe, fluxUp becomes 1 if the error is greater than fluxBand. It becomes 0 if the error is less than minus fluxBand. Otherwise it holds.
- R4: torqueDemand is coded 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1, and never takes 2'b10. On a strobe, the torque error (torqueRef minus torqueEst) being greater than torqueBand gives +1, and being less than minus torqueBand gives -1.
- R5: From +1, an error below zero but not below minus torqueBand returns the demand to 0. From -1, an error above zero but not above torqueBand returns it to 0. Errors inside the band that do not cross zero hold the demand. From 0, errors inside the band keep it at 0.
- R6: Band widths and magnitudes presented between strobes have no effect. Only their values in the strobe cycle are used.
- R7: Active vectors are coded {sA,sB,sC}: V1=100, V2=110, V3=010, V4=011, V5=001, V6=101. In sector k, the block applies V(k+1) for flux up with torque +1, V(k+2) for flux down with torque +1, V(k-1) for flux up with torque -1, and V(k-2) for flux down with torque -1.
- R8: Vector indices wrap modulo 6. For example, sector 6 with flux up and torque +1 gives V1, and sector 1 with flux down and torque -1 gives V5.
- R9: With torque demand 0, the block outputs 000 if the previously buffered legState has at most one bit set, and 111 otherwise.
- R10: A strobe with sector 0 or 7 buffers 000. The comparators still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | Control-period strobe |
| fluxRef | input | DATA_W | Commanded flux magnitude, signed |
| fluxEst | input | DATA_W | Estimated flux magnitude, signed |
| torqueRef | input | DATA_W | Commanded torque, signed |
| torqueEst | input | DATA_W | Estimated torque, signed |
| fluxBand | input | DATA_W-1 | Flux hysteresis half-width, unsigned |
| torqueBand | input | DATA_W-1 | Torque hysteresis half-width, unsigned |
| sector | input | 3 | Flux sector, valid 1 to 6 |
| fluxUp | output | 1 | Flux demand state |
| torqueDemand | output | 2 | Torque demand state, two's complement |
| legState | output | 3 | Buffered {sA,sB,sC} |
| legValid | output | 1 | Pulse marking a fresh legState |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows each strobe;
- all state holds between strobes;
- the torque code stays legal;
- a flux error outside the band forces fluxUp;
- zero torque yields one of the two zero vectors;
- a nonzero torque demand in a legal sector yields a vector with one or two legs high;
- an illegal sector yields 000.

Only the bench's scenarios can show the rest:
- the exact vector chosen per sector and demand, including modulo-6 wrap;
- the return of the torque demand to zero when the error crosses zero;
- which zero vector follows a given previous vector;
- that bands changed between strobes are ignored.

The bench covers these with directed sequences and a long randomized run against its reference model.

// File: rtl/dtc_sel_pkg.sv
package dtc_sel_pkg;

  typedef struct packed {
    logic loadDemand;
    logic loadVector;
  } dtcCtrl_t;

  localparam logic [1:0] TQ_POS  = 2'b01;
  localparam logic [1:0] TQ_ZERO = 2'b00;
  localparam logic [1:0] TQ_NEG  = 2'b11;

  function automatic logic [2:0] activeVector(input logic [2:0] idx);
    case (idx)
      3'd0:    activeVector = 3'b100;
      3'd1:    activeVector = 3'b110;
      3'd2:    activeVector = 3'b010;
      3'd3:    activeVector = 3'b011;
      3'd4:    activeVector = 3'b001;
      default: activeVector = 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/dtc_sel_ctrl.sv
module dtc_sel_ctrl
  import dtc_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycleStrobe,
  output dtcCtrl_t ctrl,
  output logic     legValid
);

  always_comb begin
    ctrl.loadDemand = cycleStrobe;
    ctrl.loadVector = cycleStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) legValid <= 1'b0;
    else       legValid <= cycleStrobe;
  end

endmodule

// File: rtl/dtc_sel_datapath.sv
module dtc_sel_datapath
  import dtc_sel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtcCtrl_t          ctrl,
  input  logic [DATA_W-1:0] fluxRef,
  input  logic [DATA_W-1:0] fluxEst,
  input  logic [DATA_W-1:0] torqueRef,
  input  logic [DATA_W-1:0] torqueEst,
  input  logic [DATA_W-2:0] fluxBand,
  input  logic [DATA_W-2:0] torqueBand,
  input  logic [2:0]        sector,
  output logic              fluxUp,
  output logic [1:0]        torqueDemand,
  output logic [2:0]        legState
);

  localparam int ERR_W = DATA_W + 1;

  logic signed [ERR_W-1:0] fluxErr, torqueErr;
  logic signed [ERR_W-1:0] fluxHi, fluxLo, torqueHi, torqueLo;
  logic                    fluxNext;
  logic [1:0]              torqueNext;
  logic [2:0]              vectorNext;
  logic [2:0]              baseIdx, offset;
  logic [3:0]              sumIdx;
  logic                    sectorOk;

  always_comb begin
    fluxErr   = $signed({fluxRef[DATA_W-1], fluxRef})   - $signed({fluxEst[DATA_W-1], fluxEst});
    torqueErr = $signed({torqueRef[DATA_W-1], torqueRef}) - $signed({torqueEst[DATA_W-1], torqueEst});
    fluxHi    = $signed({2'b00, fluxBand});
    fluxLo    = -fluxHi;
    torqueHi  = $signed({2'b00, torqueBand});
    torqueLo  = -torqueHi;
  end

  // two-level flux comparator
  always_comb begin
    fluxNext = fluxUp;
    if (fluxErr > fluxHi)      fluxNext = 1'b1;
    else if (fluxErr < fluxLo) fluxNext = 1'b0;
  end

  // three-level torque comparator with return to zero on crossing
  always_comb begin
    torqueNext = torqueDemand;
    case (torqueDemand)
      TQ_POS: begin
        if (torqueErr < torqueLo)              torqueNext = TQ_NEG;
        else if (torqueErr < 0)                torqueNext = TQ_ZERO;
      end
      TQ_NEG: begin
        if (torqueErr > torqueHi)              torqueNext = TQ_POS;
        else if (torqueErr > 0)                torqueNext = TQ_ZERO;
      end
      default: begin
        if (torqueErr > torqueHi)              torqueNext = TQ_POS;
        else if (torqueErr < torqueLo)         torqueNext = TQ_NEG;
        else                                   torqueNext = TQ_ZERO;
      end
    endcase
  end

  // switching table
  always_comb begin
    sectorOk = (sector != 3'd0) && (sector != 3'd7);
    baseIdx  = sector - 3'd1;
    case ({fluxNext, torqueNext})
      {1'b1, TQ_POS}: offset = 3'd1;
      {1'b0, TQ_POS}: offset = 3'd2;
      {1'b1, TQ_NEG}: offset = 3'd5;
      default:        offset = 3'd4;
    endcase
    sumIdx = {1'b0, baseIdx} + {1'b0, offset};
    if (sumIdx >= 4'd6) sumIdx = sumIdx - 4'd6;
    if (!sectorOk)
      vectorNext = 3'b000;
    else if (torqueNext == TQ_ZERO)
      vectorNext = ($countones(legState) <= 1) ? 3'b000 : 3'b111;
    else
      vectorNext = activeVector(sumIdx[2:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fluxUp       <= 1'b0;
      torqueDemand <= TQ_ZERO;
    end else if (ctrl.loadDemand) begin
      fluxUp       <= fluxNext;
      torqueDemand <= torqueNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                legState <= 3'b000;
    else if (ctrl.loadVector) legState <= vectorNext;
  end

endmodule

// File: rtl/dtc_vector_select.sv
module dtc_vector_select
  import dtc_sel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStrobe,
  input  logic [DATA_W-1:0] fluxRef,
  input  logic [DATA_W-1:0] fluxEst,
  input  logic [DATA_W-1:0] torqueRef,
  input  logic [DATA_W-1:0] torqueEst,
  input  logic [DATA_W-2:0] fluxBand,
  input  logic [DATA_W-2:0] torqueBand,
  input  logic [2:0]        sector,
  output logic              fluxUp,
  output logic [1:0]        torqueDemand,
  output logic [2:0]        legState,
  output logic              legValid
);

  dtcCtrl_t ctrl;

  dtc_sel_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe),
    .ctrl(ctrl), .legValid(legValid)
  );

  dtc_sel_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .fluxRef(fluxRef), .fluxEst(fluxEst),
    .torqueRef(torqueRef), .torqueEst(torqueEst),
    .fluxBand(fluxBand), .torqueBand(torqueBand),
    .sector(sector),
    .fluxUp(fluxUp), .torqueDemand(torqueDemand), .legState(legState)
  );

endmodule

// File: rtl/dtc_vector_select_chk.sv
module dtc_vector_select_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleStrobe,
  input logic [DATA_W-1:0] fluxRef,
  input logic [DATA_W-1:0] fluxEst,
  input logic [DATA_W-2:0] fluxBand,
  input logic [2:0]        sector,
  input logic              fluxUp,
  input logic [1:0]        torqueDemand,
  input logic [2:0]        legState,
  input logic              legValid
);

  logic signed [DATA_W:0] chkFluxErr, chkBand;
  assign chkFluxErr = $signed({fluxRef[DATA_W-1], fluxRef}) - $signed({fluxEst[DATA_W-1], fluxEst});
  assign chkBand    = $signed({2'b00, fluxBand});

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycleStrobe |=> legValid); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStrobe |=> (!legValid && $stable(legState) && $stable(fluxUp) && $stable(torqueDemand))); // R2

  AST_TORQUE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    torqueDemand != 2'b10); // R4

  AST_FLUX_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && chkFluxErr > chkBand) |=> fluxUp); // R3

  AST_FLUX_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && chkFluxErr < -chkBand) |=> !fluxUp); // R3

  AST_ZERO_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (legValid && torqueDemand == 2'b00) |-> (legState == 3'b000 || legState == 3'b111)); // R9

  AST_ACTIVE_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && sector != 3'd0 && sector != 3'd7) |=>
      (torqueDemand == 2'b00 || $countones(legState) == 1 || $countones(legState) == 2)); // R7

  AST_BAD_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && (sector == 3'd0 || sector == 3'd7)) |=> legState == 3'b000); // R10

endmodule

bind dtc_vector_select dtc_vector_select_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe),
  .fluxRef(fluxRef), .fluxEst(fluxEst), .fluxBand(fluxBand),
  .sector(sector), .fluxUp(fluxUp), .torqueDemand(torqueDemand),
  .legState(legState), .legValid(legValid)
);

// File: tb/sim_dtc_vector_select.sv
module sim_dtc_vector_select;

  localparam int DW       = 16;
  localparam int CLK_HALF = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cycleStrobe = 1'b0;
  logic [DW-1:0] fluxRef = '0, fluxEst = '0, torqueRef = '0, torqueEst = '0;
  logic [DW-2:0] fluxBand = '0, torqueBand = '0;
  logic [2:0]    sector = 3'd1;
  logic          fluxUp, legValid;
  logic [1:0]    torqueDemand;
  logic [2:0]    legState;

  int compared = 0;
  int mismatched = 0;

  always #CLK_HALF clk = ~clk;

  dtc_vector_select #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe),
    .fluxRef(fluxRef), .fluxEst(fluxEst), .torqueRef(torqueRef), .torqueEst(torqueEst),
    .fluxBand(fluxBand), .torqueBand(torqueBand), .sector(sector),
    .fluxUp(fluxUp), .torqueDemand(torqueDemand), .legState(legState), .legValid(legValid)
  );

  // reference model
  int mFlux, mTq, mVec, mValid;

  function automatic int vecOf(int i);
    case (i)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic int ones3(int v);
    return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFlux = 0; mTq = 0; mVec = 0; mValid = 0;
    end else begin
      mValid = cycleStrobe ? 1 : 0;
      if (cycleStrobe) begin
        int ef, et, hf, ht, k, step;
        ef = int'($signed(fluxRef)) - int'($signed(fluxEst));
        et = int'($signed(torqueRef)) - int'($signed(torqueEst));
        hf = int'(fluxBand);
        ht = int'(torqueBand);
        if (ef > hf) mFlux = 1;
        else if (ef < -hf) mFlux = 0;
        if (et > ht) mTq = 1;
        else if (et < -ht) mTq = -1;
        else if (mTq == 1 && et < 0) mTq = 0;
        else if (mTq == -1 && et > 0) mTq = 0;
        k = int'(sector);
        if (k < 1 || k > 6) mVec = 0;
        else if (mTq == 0) mVec = (ones3(mVec) <= 1) ? 0 : 7;
        else begin
          if (mTq == 1) step = mFlux ? 1 : 2;
          else          step = mFlux ? -1 : -2;
          mVec = vecOf(((k - 1 + step) % 6 + 6) % 6);
        end
      end
    end
  end

  function automatic int tqCode(int t);
    return (t == 1) ? 1 : ((t == -1) ? 3 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one cycle and compare every output to the model
  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      check("R2 legValid", int'(legValid), mValid);
      check("R3 fluxUp", int'(fluxUp), mFlux);
      check("R4 torqueDemand", int'(torqueDemand), tqCode(mTq));
      check("R7 legState", int'(legState), mVec);
    end
  endtask

  task automatic setIn(input int fe, input int te, input int fb, input int tb, input int sec);
    fluxRef    = DW'(fe);
    fluxEst    = '0;
    torqueRef  = DW'(te);
    torqueEst  = '0;
    fluxBand   = (DW-1)'(fb);
    torqueBand = (DW-1)'(tb);
    sector     = 3'(sec);
  endtask

  task automatic strobe(input int fe, input int te, input int fb, input int tb, input int sec);
    setIn(fe, te, fb, tb, sec);
    cycleStrobe = 1'b1;
    tick();
    cycleStrobe = 1'b0;
  endtask

  initial begin
    #(CLK_HALF * 400000);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 legState", int'(legState), 0);
    check("R1 legValid", int'(legValid), 0);
    check("R1 fluxUp", int'(fluxUp), 0);
    check("R1 torqueDemand", int'(torqueDemand), 0);

    strobe(20, 20, 10, 10, 1);
    check("R7 s1 up/+1", int'(legState), 3'b110);
    check("R2 pulse", int'(legValid), 1);
    strobe(-20, 5, 10, 10, 1);
    check("R7 s1 down/+1", int'(legState), 3'b010);
    strobe(0, -5, 10, 10, 1);
    check("R5 return to zero", int'(torqueDemand), 0);
    check("R9 zero after 010", int'(legState), 3'b000);
    strobe(0, -20, 10, 10, 1);
    check("R8 s1 down/-1 wraps", int'(legState), 3'b001);
    strobe(20, 20, 10, 10, 6);
    check("R8 s6 up/+1 wraps", int'(legState), 3'b100);
    strobe(20, 20, 10, 10, 1);
    strobe(0, -5, 10, 10, 1);
    check("R9 zero after 110", int'(legState), 3'b111);

    setIn(-50, -50, 2, 2, 3);
    tick(); tick();
    check("R6 no strobe legState", int'(legState), 3'b111);
    check("R6 no strobe fluxUp", int'(fluxUp), 1);
    strobe(-20, 0, 100, 100, 2);
    check("R6 band sampled at strobe", int'(fluxUp), 1);
    strobe(-20, 20, 10, 10, 7);
    check("R10 bad sector", int'(legState), 3'b000);
    check("R3 flux lowers on bad sector", int'(fluxUp), 0);

    for (int n = 0; n < 4000; n++) begin
      cycleStrobe = ($urandom % 3) == 0;
      setIn(int'($urandom % 61) - 30, int'($urandom % 61) - 30,
            int'($urandom % 16), int'($urandom % 16),
            (($urandom % 10) == 0) ? int'($urandom % 8) : 1 + int'($urandom % 6));
      fluxEst   = DW'(int'($urandom % 21) - 10);
      torqueEst = DW'(int'($urandom % 21) - 10);
      tick();
    end
    cycleStrobe = 1'b0;
    tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule